// File: doc/BRIEF.md
# Branch Direction and Target Predictor with Static Fallback

This block predicts, for each branch the fetch stage presents, whether it will be taken and where it goes. It is keyed on the branch's linear address, so the answer is ready before the instruction is decoded. A four-way set-associative table holds 4096 entries in total. Each entry keeps a tag, a 2-bit saturating counter and a target. When the table has no entry for the address, the direction follows the sign of the supplied displacement: backward branches are predicted taken and forward ones not taken. The target in that case is the address plus the displacement.

Calls and returns use a 16-entry return-address stack. A call pushes the address of the instruction after it. A return pops that stack and predicts the popped address. The table is written only from the update port, which is driven when a branch retires. Lookups never change the table or its replacement state.

Every valid lookup is accepted; there is no back-pressure, and the prediction appears on the outputs one clock later. The update port is likewise a plain strobe that is taken every cycle it is asserted.

Top module: `brpred_core`

## Requirements
- R1: The prediction outputs are registered. `pr_valid` is 1 in the cycle after a lookup (`lk_valid`=1) and 0 after a cycle without one. After reset `pr_valid` is 0 and the table holds no entries.
- R2: On a table hit for a lookup that is neither a call nor a return, `pr_hit`=1. `pr_taken` is 1 exactly when the entry's counter is 2 or 3, and `pr_target` is the stored target.
- R3: On a table miss for a lookup that is neither a call nor a return, `pr_hit`=0 and `pr_target` = `lk_pc` + `lk_disp` (two's complement). `pr_taken` is the displacement's sign bit, so a negative displacement predicts taken.
- R4: An update that hits moves the entry's counter one step toward the outcome, saturating at 0 and 3. The stored target is replaced by `up_target` only when `up_taken`=1.
- R5: An update that misses allocates a way in the set. Its counter starts at 2 if taken and at 1 if not taken, and `up_target` is stored in either case.
- R6: On allocation, the lowest-numbered invalid way of the set is chosen. If every way is valid, a 3-bit tree pseudo-LRU picks the victim; that state is refreshed only by updates. After four allocations into an empty set followed by a fifth, the first branch allocated is the one evicted.
- R7: When a lookup and an update occur in the same cycle, the update is applied. The lookup is answered from the table contents as they were before that update.
- R8: A call lookup (`lk_call`=1) is predicted taken, with its target chosen as in R2/R3, and it pushes `lk_next_pc`. `lk_call` and `lk_ret` must never both be 1 on a valid lookup.
- R9: A return lookup (`lk_ret`=1) pops the stack and predicts taken, with `pr_hit`=0 and `pr_target` equal to the most recently pushed address still on the stack. When the stack is empty, `pr_valid`=0.
- R10: The stack holds 16 addresses. A push onto a full stack overwrites the oldest entry, so the 16 most recent pushes are returned in reverse order and the next return finds the stack empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_pc | input | 32 | Linear address of the branch looked up |
| lk_disp | input | 32 | Signed branch displacement for the static rule |
| lk_call | input | 1 | Lookup is a call |
| lk_ret | input | 1 | Lookup is a return |
| lk_next_pc | input | 32 | Return address pushed by a call |
| up_valid | input | 1 | Retirement update strobe |
| up_pc | input | 32 | Linear address of the retiring branch |
| up_taken | input | 1 | Resolved direction |
| up_target | input | 32 | Resolved target |
| pr_valid | output | 1 | Prediction valid |
| pr_taken | output | 1 | Predicted taken |
| pr_hit | output | 1 | Prediction came from the table |
| pr_target | output | 32 | Predicted target |

## Verification
The bench steps one branch through the full counter range, with extra steps at both ends. A counter that wraps instead of saturating then flips the next prediction, and a target written on a not-taken outcome shows up as a wrong target. It fills one set with four branches and then adds a fifth; a replacement that ignores invalid ways or evicts the wrong way leaves the first branch still hitting, or makes the second one miss. A lookup that meets an allocating update in the same cycle must still get the static answer; a design that forwards the write reports a hit one cycle early. The stack is driven through nesting, underflow and a 17-deep overflow, where a design without wrap-around returns stale addresses or reports a valid prediction on an empty stack.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_WEAK_T = 2'd2;
  localparam ctr_t CTR_WEAK_N = 2'd1;

  function automatic ctr_t ctr_next(ctr_t c, logic tk);
    if (tk) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    else    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_way.sv
module bp_way #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 1024,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output bp_pkg::ctr_t      rd_ctr,
  output logic [ADDR_W-1:0] rd_tgt,
  input  logic [IDX_W-1:0]  up_idx,
  input  logic [TAG_W-1:0]  up_tag,
  output logic              up_hit,
  output logic              up_vld,
  output bp_pkg::ctr_t      up_ctr,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  bp_pkg::ctr_t      wr_ctr,
  input  logic              wr_tgt_en,
  input  logic [ADDR_W-1:0] wr_tgt
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  bp_pkg::ctr_t      ctr_q [SETS];
  logic [ADDR_W-1:0] tgt_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[up_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[up_idx] <= wr_tag;
      ctr_q[up_idx] <= wr_ctr;
      if (wr_tgt_en) tgt_q[up_idx] <= wr_tgt;
    end
  end

  assign rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_ctr = ctr_q[rd_idx];
  assign rd_tgt = tgt_q[rd_idx];
  assign up_vld = valid_q[up_idx];
  assign up_hit = up_vld && (tag_q[up_idx] == up_tag);
  assign up_ctr = ctr_q[up_idx];
endmodule

// File: rtl/bp_plru.sv
module bp_plru #(
  parameter int SETS = 1024,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             touch_en,
  input  logic [1:0]       touch_way,
  output logic [1:0]       victim
);
  logic [2:0] tree_q [SETS];
  logic [2:0] cur;

  assign cur    = tree_q[idx];
  assign victim = cur[0] ? (cur[2] ? 2'd3 : 2'd2) : (cur[1] ? 2'd1 : 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= 3'b000;
    end else if (touch_en) begin
      case (touch_way)
        2'd0:    tree_q[idx] <= {cur[2], 1'b1, 1'b1};
        2'd1:    tree_q[idx] <= {cur[2], 1'b0, 1'b1};
        2'd2:    tree_q[idx] <= {1'b1, cur[1], 1'b0};
        default: tree_q[idx] <= {1'b0, cur[1], 1'b0};
      endcase
    end
  end
endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic [ADDR_W-1:0] top_addr,
  output logic              nonempty,
  output logic [CNT_W-1:0]  cnt
);
  logic [ADDR_W-1:0] stk_q [DEPTH];
  logic [PTR_W-1:0]  ptr_q, ptr_inc, ptr_dec;
  logic [CNT_W-1:0]  cnt_q;

  assign ptr_inc  = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  assign ptr_dec  = (ptr_q == '0) ? PTR_W'(DEPTH - 1) : ptr_q - 1'b1;
  assign top_addr = stk_q[ptr_dec];
  assign nonempty = (cnt_q != '0);
  assign cnt      = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push) begin
      ptr_q <= ptr_inc;
      if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop && nonempty) begin
      ptr_q <= ptr_dec;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) stk_q[ptr_q] <= push_addr;
  end
endmodule

// File: rtl/brpred_core.sv
module brpred_core #(
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 4096,
  parameter int RAS_DEPTH = 16,
  localparam int WAYS  = 4,
  localparam int SETS  = ENTRIES / WAYS,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int CNT_W = $clog2(RAS_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic [ADDR_W-1:0] lk_disp,
  input  logic              lk_call,
  input  logic              lk_ret,
  input  logic [ADDR_W-1:0] lk_next_pc,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target,
  output logic              pr_valid,
  output logic              pr_taken,
  output logic              pr_hit,
  output logic [ADDR_W-1:0] pr_target
);
  import bp_pkg::*;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  assign lk_idx = lk_pc[IDX_W-1:0];
  assign lk_tag = lk_pc[ADDR_W-1:IDX_W];
  assign up_idx = up_pc[IDX_W-1:0];
  assign up_tag = up_pc[ADDR_W-1:IDX_W];

  logic [WAYS-1:0]   rd_hit_w, up_hit_w, up_vld_w, wr_en_w;
  ctr_t              rd_ctr_w [WAYS];
  ctr_t              up_ctr_w [WAYS];
  logic [ADDR_W-1:0] rd_tgt_w [WAYS];
  ctr_t              wr_ctr;
  logic              wr_tgt_en;
  logic [1:0]        wr_way, plru_victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    bp_way #(.ADDR_W(ADDR_W), .SETS(SETS)) u_way (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_idx), .rd_tag(lk_tag),
      .rd_hit(rd_hit_w[w]), .rd_ctr(rd_ctr_w[w]), .rd_tgt(rd_tgt_w[w]),
      .up_idx(up_idx), .up_tag(up_tag),
      .up_hit(up_hit_w[w]), .up_vld(up_vld_w[w]), .up_ctr(up_ctr_w[w]),
      .wr_en(wr_en_w[w]), .wr_tag(up_tag), .wr_ctr(wr_ctr),
      .wr_tgt_en(wr_tgt_en), .wr_tgt(up_target)
    );
    assign wr_en_w[w] = up_valid && (wr_way == 2'(w));
  end

  bp_plru #(.SETS(SETS)) u_plru (
    .clk(clk), .rst_n(rst_n), .idx(up_idx),
    .touch_en(up_valid), .touch_way(wr_way), .victim(plru_victim)
  );

  // Lookup side: merge the ways (at most one hits).
  logic              lk_any_hit;
  ctr_t              lk_ctr;
  logic [ADDR_W-1:0] lk_tgt;
  always_comb begin
    lk_any_hit = |rd_hit_w;
    lk_ctr     = '0;
    lk_tgt     = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rd_hit_w[w]) begin
        lk_ctr = lk_ctr | rd_ctr_w[w];
        lk_tgt = lk_tgt | rd_tgt_w[w];
      end
    end
  end

  // Update side: hit way, else first invalid way, else pseudo-LRU victim.
  always_comb begin
    logic       found_inv;
    logic [1:0] inv_way;
    logic [1:0] hit_way;
    ctr_t       old_ctr;
    found_inv = 1'b0;
    inv_way   = '0;
    hit_way   = '0;
    old_ctr   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!up_vld_w[w]) begin
        found_inv = 1'b1;
        inv_way   = 2'(w);
      end
      if (up_hit_w[w]) begin
        hit_way = 2'(w);
        old_ctr = up_ctr_w[w];
      end
    end
    if (|up_hit_w) begin
      wr_way    = hit_way;
      wr_ctr    = ctr_next(old_ctr, up_taken);
      wr_tgt_en = up_taken;
    end else begin
      wr_way    = found_inv ? inv_way : plru_victim;
      wr_ctr    = up_taken ? CTR_WEAK_T : CTR_WEAK_N;
      wr_tgt_en = 1'b1;
    end
  end

  logic [ADDR_W-1:0] ras_top;
  logic              ras_nonempty;
  logic [CNT_W-1:0]  ras_cnt;
  bp_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk(clk), .rst_n(rst_n),
    .push(lk_valid && lk_call), .push_addr(lk_next_pc),
    .pop(lk_valid && lk_ret),
    .top_addr(ras_top), .nonempty(ras_nonempty), .cnt(ras_cnt)
  );

  logic              nx_taken, nx_hit;
  logic [ADDR_W-1:0] nx_tgt, static_tgt;
  assign static_tgt = lk_pc + lk_disp;
  always_comb begin
    if (lk_ret) begin
      nx_taken = 1'b1;
      nx_hit   = 1'b0;
      nx_tgt   = ras_top;
    end else begin
      nx_hit   = lk_any_hit;
      nx_tgt   = lk_any_hit ? lk_tgt : static_tgt;
      nx_taken = lk_call ? 1'b1 : (lk_any_hit ? lk_ctr[1] : lk_disp[ADDR_W-1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr_valid  <= 1'b0;
      pr_taken  <= 1'b0;
      pr_hit    <= 1'b0;
      pr_target <= '0;
    end else begin
      pr_valid <= lk_valid && (!lk_ret || ras_nonempty);
      if (lk_valid) begin
        pr_taken  <= nx_taken;
        pr_hit    <= nx_hit;
        pr_target <= nx_tgt;
      end
    end
  end
endmodule

// File: rtl/brpred_chk.sv
module brpred_chk #(
  parameter int ADDR_W    = 32,
  parameter int RAS_DEPTH = 16,
  parameter int CNT_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_call,
  input logic              lk_ret,
  input logic [ADDR_W-1:0] lk_pc,
  input logic [ADDR_W-1:0] lk_disp,
  input logic              pr_valid,
  input logic              pr_taken,
  input logic              pr_hit,
  input logic [ADDR_W-1:0] pr_target,
  input logic [CNT_W-1:0]  ras_cnt
);
  // R8
  call_ret_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> !(lk_call && lk_ret));

  // R1
  valid_follows_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid |-> $past(lk_valid));

  // R3
  static_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_valid && !pr_hit && !$past(lk_call) && !$past(lk_ret)) |->
      (pr_taken == $past(lk_disp[ADDR_W-1]) && pr_target == $past(lk_pc + lk_disp)));

  // R8
  call_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_valid && $past(lk_call)) |-> pr_taken);

  // R9
  ret_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_valid && $past(lk_ret)) |-> (pr_taken && !pr_hit));

  // R9
  ret_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_valid && lk_ret) && $past(ras_cnt) == '0) |-> !pr_valid);

  // R10
  ras_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ras_cnt <= CNT_W'(RAS_DEPTH));
endmodule

bind brpred_core brpred_chk #(.ADDR_W(ADDR_W), .RAS_DEPTH(RAS_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_call(lk_call), .lk_ret(lk_ret),
  .lk_pc(lk_pc), .lk_disp(lk_disp), .pr_valid(pr_valid), .pr_taken(pr_taken),
  .pr_hit(pr_hit), .pr_target(pr_target), .ras_cnt(ras_cnt)
);

// File: tb/brpred_core_test.sv
module brpred_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_call, lk_ret, up_valid, up_taken;
  logic [31:0] lk_pc, lk_disp, lk_next_pc, up_pc, up_target;
  logic        pr_valid, pr_taken, pr_hit;
  logic [31:0] pr_target;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  brpred_core uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_disp(lk_disp),
    .lk_call(lk_call), .lk_ret(lk_ret), .lk_next_pc(lk_next_pc),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target),
    .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_hit(pr_hit), .pr_target(pr_target)
  );

  typedef struct packed {
    logic        upd;    // 0: lookup, 1: retirement update
    logic [31:0] pc;
    logic [31:0] arg;    // displacement for lookup, target for update
    logic        tk;     // resolved direction for update
    logic        e_tk;
    logic        e_hit;
    logic [31:0] e_tgt;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h1040, 32'hFFFF_FFF0, 1'b0, 1'b1, 1'b0, 32'h1030},  // R3 backward miss
    '{1'b0, 32'h1040, 32'h0000_0020, 1'b0, 1'b0, 1'b0, 32'h1060},  // R3 forward miss
    '{1'b1, 32'h1040, 32'h0000_2000, 1'b1, 1'b0, 1'b0, 32'h0},     // R5 alloc taken -> 2
    '{1'b0, 32'h1040, 32'h0000_0020, 1'b0, 1'b1, 1'b1, 32'h2000},  // R2 R5
    '{1'b1, 32'h1040, 32'h0000_5555, 1'b0, 1'b0, 1'b0, 32'h0},     // R4 -> 1, target kept
    '{1'b0, 32'h1040, 32'h0000_0020, 1'b0, 1'b0, 1'b1, 32'h2000},  // R4
    '{1'b1, 32'h1040, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 32'h0},     // -> 0
    '{1'b1, 32'h1040, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 32'h0},     // R4 stays 0
    '{1'b1, 32'h1040, 32'h0000_2000, 1'b1, 1'b0, 1'b0, 32'h0},     // -> 1
    '{1'b0, 32'h1040, 32'h0000_0020, 1'b0, 1'b0, 1'b1, 32'h2000},  // R4 low saturation
    '{1'b1, 32'h1040, 32'h0000_2000, 1'b1, 1'b0, 1'b0, 32'h0},     // -> 2
    '{1'b0, 32'h1040, 32'h0000_0020, 1'b0, 1'b1, 1'b1, 32'h2000},  // R2
    '{1'b1, 32'h1040, 32'h0000_2000, 1'b1, 1'b0, 1'b0, 32'h0},     // -> 3
    '{1'b1, 32'h1040, 32'h0000_2000, 1'b1, 1'b0, 1'b0, 32'h0},     // R4 stays 3
    '{1'b1, 32'h1040, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 32'h0},     // -> 2
    '{1'b0, 32'h1040, 32'h0000_0020, 1'b0, 1'b1, 1'b1, 32'h2000},  // R4 high saturation
    '{1'b1, 32'h1040, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 32'h0},     // -> 1
    '{1'b0, 32'h1040, 32'h0000_0020, 1'b0, 1'b0, 1'b1, 32'h2000},  // R2
    '{1'b1, 32'h2080, 32'h0000_3000, 1'b0, 1'b0, 1'b0, 32'h0},     // R5 alloc not taken -> 1
    '{1'b0, 32'h2080, 32'hFFFF_FFF8, 1'b0, 1'b0, 1'b1, 32'h3000},  // R5 hit overrides static
    '{1'b1, 32'h1040, 32'h0000_2400, 1'b1, 1'b0, 1'b0, 32'h0},     // R4 -> 2, new target
    '{1'b0, 32'h1040, 32'h0000_0020, 1'b0, 1'b1, 1'b1, 32'h2400}   // R4
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic cyc(input logic lv, input logic [31:0] pc, input logic [31:0] disp,
                     input logic call, input logic ret, input logic [31:0] nxt,
                     input logic uv, input logic [31:0] upc, input logic utk,
                     input logic [31:0] utgt);
    @(negedge clk);
    lk_valid = lv; lk_pc = pc; lk_disp = disp; lk_call = call; lk_ret = ret;
    lk_next_pc = nxt; up_valid = uv; up_pc = upc; up_taken = utk; up_target = utgt;
    @(posedge clk);
    #1;
  endtask

  task automatic look(input logic [31:0] pc, input logic [31:0] disp);
    cyc(1'b1, pc, disp, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    cyc(1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, pc, tk, tgt);
  endtask

  task automatic call_op(input logic [31:0] pc, input logic [31:0] disp, input logic [31:0] nxt);
    cyc(1'b1, pc, disp, 1'b1, 1'b0, nxt, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic ret_op();
    cyc(1'b1, 32'h8000, 32'h0, 1'b0, 1'b1, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic idle();
    cyc(1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic expect_pred(input string what, input logic tk, input logic hit,
                             input logic [31:0] tgt);
    chk({what, " valid"}, {31'b0, pr_valid}, 32'd1);
    chk({what, " taken"}, {31'b0, pr_taken}, {31'b0, tk});
    chk({what, " hit"}, {31'b0, pr_hit}, {31'b0, hit});
    chk({what, " target"}, pr_target, tgt);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lk_valid = 0; lk_pc = 0; lk_disp = 0; lk_call = 0; lk_ret = 0; lk_next_pc = 0;
    up_valid = 0; up_pc = 0; up_taken = 0; up_target = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset pr_valid", {31'b0, pr_valid}, 32'd0);
    idle();
    chk("R1 no lookup pr_valid", {31'b0, pr_valid}, 32'd0);

    // Table walk: counter, static rule, allocation and target rules.
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].upd) upd(VEC[i].pc, VEC[i].tk, VEC[i].arg);
      else begin
        look(VEC[i].pc, VEC[i].arg);
        expect_pred($sformatf("R2 R3 R4 R5 vector %0d", i),
                    VEC[i].e_tk, VEC[i].e_hit, VEC[i].e_tgt);
      end
    end

    // R6: fill set 0x300 with four tags, then a fifth evicts the first.
    for (int t = 1; t <= 5; t++) upd((t << 10) | 32'h300, 1'b1, 32'h9000 + t);
    look(32'h0700, 32'h4);
    expect_pred("R6 first allocated evicted", 1'b0, 1'b0, 32'h0704);
    look(32'h0B00, 32'h4);
    expect_pred("R6 second kept", 1'b1, 1'b1, 32'h9002);
    look(32'h1700, 32'h4);
    expect_pred("R6 fifth placed", 1'b1, 1'b1, 32'h9005);

    // R7: lookup and allocating update to the same entry in one cycle.
    cyc(1'b1, 32'h5100, 32'h10, 1'b0, 1'b0, 32'h0, 1'b1, 32'h5100, 1'b1, 32'h7000);
    expect_pred("R7 lookup sees old contents", 1'b0, 1'b0, 32'h5110);
    look(32'h5100, 32'h10);
    expect_pred("R7 update applied", 1'b1, 1'b1, 32'h7000);

    // R8 R9: nested calls and returns, then underflow.
    call_op(32'h0100, 32'h40, 32'h0105);
    expect_pred("R8 call predicted taken", 1'b1, 1'b0, 32'h0140);
    call_op(32'h0200, 32'h40, 32'h0205);
    call_op(32'h0300, 32'h40, 32'h0305);
    ret_op();
    expect_pred("R9 return 3", 1'b1, 1'b0, 32'h0305);
    ret_op();
    expect_pred("R9 return 2", 1'b1, 1'b0, 32'h0205);
    ret_op();
    expect_pred("R9 return 1", 1'b1, 1'b0, 32'h0105);
    ret_op();
    chk("R9 underflow pr_valid", {31'b0, pr_valid}, 32'd0);

    // R10: 17 pushes keep the latest 16.
    for (int i = 1; i <= 17; i++) call_op(32'h0400, 32'h8, 32'hA000 + i);
    for (int i = 17; i >= 2; i--) begin
      ret_op();
      expect_pred($sformatf("R10 wrapped return %0d", i), 1'b1, 1'b0, 32'hA000 + i);
    end
    ret_op();
    chk("R10 empty after 16 returns", {31'b0, pr_valid}, 32'd0);
    idle();
    chk("R1 idle after returns", {31'b0, pr_valid}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule